// File: doc/BRIEF.md
# Dual-Edge PDM Channel Router

This block is the capture front end for up to four pulse-density-modulated microphones. The microphones share two serial data lines, two per line. One microphone on a line drives its bit for the rising half of the microphone clock and the other drives its bit for the falling half. The block always generates that microphone clock itself, by dividing its fast system clock. It registers each data line at both clock transitions, so every microphone clock period yields four slot bits.

Each output channel has two select bits. One picks the data line and the other picks the clock edge, so any of the four slots can feed any channel. Once per microphone clock period the block takes a snapshot of the selected bits. It then emits one word per enabled channel on a valid/ready stream, lowest channel first. Each word carries its channel index in the top byte. Filtering and buffering are left to downstream logic.

Back-pressure rules: `out_valid` and `out_word` hold steady until `out_ready` is seen high on a clock edge. A new period's snapshot is loaded only if every word of the previous period has been accepted. Otherwise the whole new period is discarded, so the sink never receives a partial or reordered period.

Top module: `pdm_dual_edge_router`

## Requirements
- R1: `pdm_clk` is always generated by the block. It is low after reset, and it toggles every `HALF_DIV` system clock cycles (default 4), so each half period lasts exactly `HALF_DIV` cycles.
- R2: The rising slot of a line is the value on that line at the system edge where `pdm_clk` goes from 0 to 1. The falling slot is the value at the edge where `pdm_clk` goes from 1 to 0. A period is complete after its falling slot is taken.
- R3: `edge_sel[n]` = 0 routes the rising slot to channel n, and 1 routes the falling slot.
- R4: `line_sel[n]` = 0 routes data line 0 (`pdm_data[0]`) to channel n, and 1 routes data line 1 (`pdm_data[1]`).
- R5: Only channels whose `chan_en` bit is 1 at a period's snapshot produce a word for that period. A newly enabled channel yields words from the first complete period, with no start-up wait. When all bits are 0, no words appear.
- R6: Within one period, words leave in strictly ascending channel index order.
- R7: Word format: bits [31:24] hold the channel index, bit 0 holds the routed slot bit, and bits [23:1] are 0.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_word` does not change.
- R9: If any word of the previous period is still pending when a new period completes, the new period is dropped entirely. Its bits never appear, and the pending words then drain unchanged.
- R10: During reset, `out_valid` is 0 and `pdm_clk` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 4 | Per-channel capture enable, bit n for channel n |
| edge_sel | input | 4 | Per-channel edge select, 0 rising, 1 falling |
| line_sel | input | 4 | Per-channel data line select |
| pdm_data | input | 2 | The two shared microphone data lines |
| pdm_clk | output | 1 | Generated microphone clock |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink accepts the word on this edge |
| out_word | output | 32 | Channel index in [31:24], routed bit in [0] |

## Verification
A wrong divider count appears as a half period that is not `HALF_DIV` cycles long, visible within one microphone clock period. A swapped edge or line register, or a wrong select decode, gives a wrong bit in bit 0 of the first word of the next period. This shows within about two periods as a mismatch against the slot pattern the bench drove. A corrupted pending mask appears as a missing, extra or out-of-order channel tag in the same period. A load that ignores the busy condition shows a changed held word during a stall, or bits from the period that should have been dropped, as soon as `out_ready` returns.

// File: rtl/pdm_router_pkg.sv
package pdm_router_pkg;
  localparam int NUM_LINES = 2;
  localparam int WORD_W    = 32;
  localparam int TAG_W     = 8;
  localparam int PAD_W     = WORD_W - TAG_W - 1;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [PAD_W-1:0] pad;
    logic             sample;
  } ch_word_t;
endpackage

// File: rtl/pdm_clk_div.sv
module pdm_clk_div #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic pdm_clk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick      = (cnt_q == LAST);
  assign rise_tick = tick & ~pdm_clk;
  assign fall_tick = tick & pdm_clk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pdm_clk <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick) pdm_clk <= ~pdm_clk;
    end
  end

  // Checker: independent count of cycles between clock transitions
  logic        clk_d_q;
  logic        seen_q;
  int unsigned since_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_d_q <= 1'b0;
      seen_q  <= 1'b0;
      since_q <= 0;
    end else begin
      clk_d_q <= pdm_clk;
      if (pdm_clk != clk_d_q) begin
        since_q <= 0;
        seen_q  <= 1'b1;
      end else begin
        since_q <= since_q + 1;
      end
    end
  end

  a_r1_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && (pdm_clk != clk_d_q)) |-> (since_q == HALF_DIV - 1));
  a_r10_reset_low: assert property (@(posedge clk)
    !rst_n |=> !pdm_clk);
endmodule

// File: rtl/pdm_edge_capture.sv
module pdm_edge_capture
  import pdm_router_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rise_tick,
  input  logic                 fall_tick,
  input  logic [NUM_LINES-1:0] pdm_data,
  output logic [NUM_LINES-1:0] rise_q,
  output logic [NUM_LINES-1:0] fall_q,
  output logic                 frame_stb
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rise_q[l] <= 1'b0;
        fall_q[l] <= 1'b0;
      end else begin
        if (rise_tick) rise_q[l] <= pdm_data[l];
        if (fall_tick) fall_q[l] <= pdm_data[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) frame_stb <= 1'b0;
    else        frame_stb <= fall_tick;
  end

  a_r2_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_tick && fall_tick));
endmodule

// File: rtl/pdm_slot_router.sv
module pdm_slot_router
  import pdm_router_pkg::*;
#(
  parameter int CHANNELS = 4
) (
  input  logic [CHANNELS-1:0]  edge_sel,
  input  logic [CHANNELS-1:0]  line_sel,
  input  logic [NUM_LINES-1:0] rise_q,
  input  logic [NUM_LINES-1:0] fall_q,
  output logic [CHANNELS-1:0]  ch_bits
);
  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    logic [NUM_LINES-1:0] edge_vec;
    assign edge_vec   = edge_sel[g] ? fall_q : rise_q;
    assign ch_bits[g] = edge_vec[line_sel[g]];
  end
endmodule

// File: rtl/pdm_ch_serializer.sv
module pdm_ch_serializer
  import pdm_router_pkg::*;
#(
  parameter int CHANNELS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_stb,
  input  logic [CHANNELS-1:0] chan_en,
  input  logic [CHANNELS-1:0] new_bits,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [WORD_W-1:0]   out_word
);
  localparam int IDX_W = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;

  logic [CHANNELS-1:0] pend_q;
  logic [CHANNELS-1:0] bits_q;
  logic [IDX_W-1:0]    cur;
  ch_word_t            word;

  always_comb begin
    cur = '0;
    for (int i = CHANNELS - 1; i >= 0; i--) begin
      if (pend_q[i]) cur = IDX_W'(i);
    end
  end

  assign out_valid   = |pend_q;
  assign word.tag    = TAG_W'(cur);
  assign word.pad    = '0;
  assign word.sample = bits_q[cur];
  assign out_word    = word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      bits_q <= '0;
    end else if (frame_stb && !out_valid) begin
      pend_q <= chan_en;
      bits_q <= new_bits;
    end else if (out_valid && out_ready) begin
      pend_q[cur] <= 1'b0;
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=>
      (!out_valid || (out_word[WORD_W-1 -: TAG_W] > $past(out_word[WORD_W-1 -: TAG_W]))));
  a_r9_no_reload_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && out_valid) |=> ($countones(pend_q) <= $countones($past(pend_q))));
  a_r7_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word[WORD_W-1 -: TAG_W] < CHANNELS));
  a_r10_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: rtl/pdm_dual_edge_router.sv
module pdm_dual_edge_router
  import pdm_router_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int CHANNELS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CHANNELS-1:0]  chan_en,
  input  logic [CHANNELS-1:0]  edge_sel,
  input  logic [CHANNELS-1:0]  line_sel,
  input  logic [NUM_LINES-1:0] pdm_data,
  output logic                 pdm_clk,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [WORD_W-1:0]    out_word
);
  logic                 rise_tick;
  logic                 fall_tick;
  logic                 frame_stb;
  logic [NUM_LINES-1:0] rise_q;
  logic [NUM_LINES-1:0] fall_q;
  logic [CHANNELS-1:0]  ch_bits;

  pdm_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .pdm_clk(pdm_clk),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  pdm_edge_capture u_cap (
    .clk(clk), .rst_n(rst_n), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .pdm_data(pdm_data), .rise_q(rise_q), .fall_q(fall_q), .frame_stb(frame_stb)
  );

  pdm_slot_router #(.CHANNELS(CHANNELS)) u_route (
    .edge_sel(edge_sel), .line_sel(line_sel),
    .rise_q(rise_q), .fall_q(fall_q), .ch_bits(ch_bits)
  );

  pdm_ch_serializer #(.CHANNELS(CHANNELS)) u_ser (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .chan_en(chan_en),
    .new_bits(ch_bits), .out_ready(out_ready),
    .out_valid(out_valid), .out_word(out_word)
  );

  // R2: a period completes just after the falling transition
  a_r2_stb_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> !pdm_clk);
endmodule

// File: tb/test_pdm_dual_edge_router.sv
module test_pdm_dual_edge_router;
  localparam int HALF = 4;
  localparam int CH   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  en = '0;
  logic [3:0]  esel = '0;
  logic [3:0]  lsel = '0;
  logic [1:0]  din = '0;
  logic        rdy = 1'b1;
  logic        pdm_clk;
  logic        out_valid;
  logic [31:0] out_word;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  logic [31:0] expq[$];

  always #5 clk = ~clk;

  pdm_dual_edge_router #(.HALF_DIV(HALF), .CHANNELS(CH)) i_pdm_dual_edge_router (
    .clk(clk), .rst_n(rst_n), .chan_en(en), .edge_sel(esel), .line_sel(lsel),
    .pdm_data(din), .pdm_clk(pdm_clk), .out_valid(out_valid),
    .out_ready(rdy), .out_word(out_word)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Stream monitor: samples 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (mon_on && out_valid && rdy) begin
      if (expq.size() == 0) begin
        check(1'b0, "R5/R6 unexpected word", out_word, 32'h0);
      end else begin
        logic [31:0] e;
        e = expq.pop_front();
        check(out_word == e, "R3/R4/R6/R7 stream word", out_word, e);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic align();
    @(negedge clk);
    while (!pdm_clk) @(negedge clk);
    while (pdm_clk) @(negedge clk);
    wait_n(2);
  endtask

  function automatic logic [31:0] exp_word(input int n, input logic [3:0] s);
    logic b;
    b = s[lsel[n] * 2 + esel[n]];
    return {8'(n), 23'd0, b};
  endfunction

  // s[2*line+edge]: edge 0 rising slot, edge 1 falling slot
  task automatic run_period(input logic [3:0] s, input bit expect_words);
    while (pdm_clk) @(negedge clk);
    din = {s[2], s[0]};
    while (!pdm_clk) @(negedge clk);
    din = {s[3], s[1]};
    while (pdm_clk) @(negedge clk);
    if (expect_words) begin
      for (int n = 0; n < CH; n++) begin
        if (en[n]) expq.push_back(exp_word(n, s));
      end
    end
    wait_n(2);
  endtask

  task automatic t_divider();
    int hi;
    int lo;
    hi = 0;
    lo = 0;
    align();
    while (!pdm_clk) @(negedge clk);
    while (pdm_clk) begin hi++; @(negedge clk); end
    while (!pdm_clk) begin lo++; @(negedge clk); end
    check(hi == HALF, "R1 high half period", 32'(hi), 32'(HALF));
    check(lo == HALF, "R1 low half period", 32'(lo), 32'(HALF));
  endtask

  task automatic t_stream(input logic [3:0] e_in, input logic [3:0] es,
                          input logic [3:0] ls, input int periods, input int seed);
    align();
    en = e_in;
    esel = es;
    lsel = ls;
    mon_on = 1'b1;
    for (int k = 0; k < periods; k++) run_period(4'((k * 7 + seed) % 16), 1'b1);
    en = '0;
    wait_n(6);
    check(expq.size() == 0, "R5 all expected words seen", 32'(expq.size()), 32'h0);
    mon_on = 1'b0;
    expq.delete();
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    align();
    esel = '0;
    lsel = '0;
    en = 4'b1111;
    rdy = 1'b0;
    run_period(4'b1011, 1'b0);
    held = {8'd0, 23'd0, 1'b1};
    check(out_valid == 1'b1, "R8 valid while stalled", 32'(out_valid), 32'h1);
    check(out_word == held, "R8 first word while stalled", out_word, held);
    run_period(4'b0100, 1'b0);
    check(out_word == held, "R8/R9 word held across dropped period", out_word, held);
    for (int n = 0; n < CH; n++) expq.push_back(exp_word(n, 4'b1011));
    mon_on = 1'b1;
    rdy = 1'b1;
    run_period(4'b0010, 1'b1);
    en = '0;
    wait_n(6);
    check(expq.size() == 0, "R9 drained without dropped period", 32'(expq.size()), 32'h0);
    mon_on = 1'b0;
    expq.delete();
  endtask

  initial begin
    wait_n(3);
    check(out_valid == 1'b0, "R10 valid low in reset", 32'(out_valid), 32'h0);
    check(pdm_clk == 1'b0, "R10 clock low in reset", 32'(pdm_clk), 32'h0);
    rst_n = 1'b1;
    t_divider();
    t_stream(4'b1111, 4'b0000, 4'b0000, 6, 1);   // R3 R4 identity on line 0 rising
    t_stream(4'b1111, 4'b0011, 4'b0101, 8, 3);   // R3 R4 mixed slots
    t_stream(4'b1111, 4'b1111, 4'b1111, 5, 9);   // R3 R4 all from line 1 falling
    t_stream(4'b0101, 4'b1010, 4'b1100, 6, 5);   // R5 R6 gaps in enable mask
    t_stream(4'b1000, 4'b1000, 4'b0000, 4, 2);   // R5 single high channel
    t_stream(4'b0000, 4'b0000, 4'b0000, 4, 4);   // R5 nothing enabled
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule